// File: doc/BRIEF.md
# Key-Protected Reset Control Register

This block is a single 32-bit control register that drives two active-high reset outputs: one held on a plug-in mezzanine card and one held on the core logic next to it. Firmware changes either reset line with one bus write. That write must carry a fixed 16-bit unlock key in its upper half together with the new reset state in its low bits. A write without the correct key is accepted on the write port but changes nothing. A stray or corrupted store therefore cannot drop the card or the core into reset, and cannot release them from it.

Both reset lines come up asserted after power-on reset. They stay asserted until software releases them with a keyed write. The read port always shows the present state of the two lines, and the key field reads back as zero. The write port is a plain write-enable and data word. The byte strobes are taken in but have no effect, so a keyed word acts as a whole. Reset synchronisation into other clock domains, the bus protocol wrapper and any sequencing timers are outside this block.

Top module: `rst_key_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `mezz_rst_o` and `core_rst_o` are both 1 and `rd_data` is 0x00000003.
- R2: A write with `wr_data[31:16] == 16'hDEAD` sets `mezz_rst_o` to `wr_data[0]` and `core_rst_o` to `wr_data[1]`, visible after the clock edge that samples the write.
- R3: A write whose `wr_data[31:16]` is not 16'hDEAD leaves both reset outputs and `rd_data` unchanged.
- R4: Only an exact match of the full 16-bit key unlocks. A key one bit off, a byte-swapped key, or the key placed in bits 15:0 all count as unkeyed writes.
- R5: `rd_data[0]` equals `mezz_rst_o`, `rd_data[1]` equals `core_rst_o`, and `rd_data[31:2]` is always zero, including the key field.
- R6: `wr_strb` has no effect. A keyed write with `wr_strb == 4'b0000` updates the reset lines the same as one with `4'b1111`.
- R7: In a keyed write, `wr_data[15:2]` is ignored. It does not alter the reset outputs and never appears on `rd_data`.
- R8: With `wr_en` low, the reset outputs hold their value on every cycle.
- R9: The key does not leave the register unlocked. An unkeyed write that immediately follows a keyed write has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write request, one word per cycle |
| wr_data | input | 32 | Write word: key in 31:16, core reset in bit 1, mezzanine reset in bit 0 |
| wr_strb | input | 4 | Byte strobes, accepted and ignored |
| rd_data | output | 32 | Current reset state in bits 1:0, zero elsewhere |
| mezz_rst_o | output | 1 | Active-high reset to the mezzanine card |
| core_rst_o | output | 1 | Active-high reset to the core logic |

## Verification
The bench goes after near-miss keys: one bit off, byte-swapped, and placed in the low half. A comparator that checks only part of the key, or the wrong half of the word, would let those writes through and toggle the resets. It also checks that the key does not linger. A design that latched an "unlocked" flag would let the write after a keyed one take effect. The bench drives keyed words with zero strobes and with junk in bits 15:2. A design that gated on strobes would miss the update, and one that stored the whole low half would show that junk on `rd_data`. It also asserts reset in the middle of a run to confirm that both lines fall back to asserted rather than keeping the last written state.

// File: rtl/rst_key_pkg.sv
package rst_key_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned KEY_W     = 16;
  localparam int unsigned STRB_W    = DATA_W / 8;
  localparam int unsigned N_RST     = 2;
  localparam int unsigned KEY_LSB   = DATA_W - KEY_W;
  localparam logic [KEY_W-1:0] KEY_VALUE = 16'hDEAD;

  // Bit positions of the reset lines inside the register word
  typedef enum int unsigned {
    RST_MEZZ = 0,
    RST_CORE = 1
  } rst_line_e;

  typedef logic [N_RST-1:0] rst_vec_t;
  localparam rst_vec_t RST_INIT = '1;
endpackage

// File: rtl/rst_key_decode.sv
module rst_key_decode
  import rst_key_pkg::*;
(
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              upd_en,
  output rst_vec_t          upd_val
);
  logic key_match;

  assign key_match = (wr_data[KEY_LSB +: KEY_W] == KEY_VALUE);
  assign upd_en    = wr_en & key_match;

  // Each reset line takes its own bit from the write word
  for (genvar g = 0; g < N_RST; g++) begin : g_line
    assign upd_val[g] = wr_data[g];
  end
endmodule

// File: rtl/rst_key_state.sv
module rst_key_state
  import rst_key_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd_en,
  input  rst_vec_t upd_val,
  output rst_vec_t state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= RST_INIT;
    else if (upd_en) state <= upd_val;
  end

  p_keyed_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> state == $past(upd_val));

  p_hold_unkeyed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(state));
endmodule

// File: rtl/rst_key_ctrl.sv
module rst_key_ctrl
  import rst_key_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  output logic [DATA_W-1:0] rd_data,
  output logic              mezz_rst_o,
  output logic              core_rst_o
);
  logic     upd_en;
  rst_vec_t upd_val;
  rst_vec_t state;

  rst_key_decode u_decode (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .upd_en  (upd_en),
    .upd_val (upd_val)
  );

  rst_key_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .upd_val (upd_val),
    .state   (state)
  );

  assign mezz_rst_o = state[RST_MEZZ];
  assign core_rst_o = state[RST_CORE];
  assign rd_data    = {{(DATA_W-N_RST){1'b0}}, state};

  // R3/R4: a word without the exact key in the upper half changes nothing
  p_nokey_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[KEY_LSB +: KEY_W] != KEY_VALUE)
      |=> $stable({core_rst_o, mezz_rst_o}));

  // R5: read port mirrors the reset pins
  p_rd_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == {core_rst_o, mezz_rst_o});

  // R6: a keyed write with every strobe low still updates
  p_strb_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_strb == '0 && wr_data[KEY_LSB +: KEY_W] == KEY_VALUE)
      |=> {core_rst_o, mezz_rst_o} == $past(wr_data[1:0]));

  // R7: junk in the middle bits of a keyed word never reaches the read port
  p_mid_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|wr_data[KEY_LSB-1:N_RST]))
      |=> rd_data[DATA_W-1:N_RST] == '0);
endmodule

// File: tb/rst_key_ctrl_tb_top.sv
module rst_key_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = 4'hF;
  logic [31:0] rd_data;
  logic        mezz_rst_o;
  logic        core_rst_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  rst_key_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_strb    (wr_strb),
    .rd_data    (rd_data),
    .mezz_rst_o (mezz_rst_o),
    .core_rst_o (core_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // pins and read port compared together; state is {core, mezz}
  task automatic check_state(input string req, input logic [1:0] exp);
    check({req, " pins"}, {30'd0, core_rst_o, mezz_rst_o}, {30'd0, exp});
    check({req, " rd_data"}, rd_data, {30'd0, exp});
  endtask

  // one write cycle; ends on the falling edge after the sampling edge
  task automatic do_write(input logic [31:0] d, input logic [3:0] s);
    wr_en = 1'b1; wr_data = d; wr_strb = s;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_strb = 4'hF;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_state("R1 during reset", 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release", 2'b11);
  endtask

  task automatic t_keyed;
    do_write(32'hDEAD_0000, 4'hF); check_state("R2 release both", 2'b00);
    do_write(32'hDEAD_0001, 4'hF); check_state("R2 mezz only", 2'b01);
    do_write(32'hDEAD_0002, 4'hF); check_state("R2 core only", 2'b10);
    do_write(32'hDEAD_0003, 4'hF); check_state("R2 both set", 2'b11);
  endtask

  task automatic t_no_key;
    do_write(32'h0000_0000, 4'hF); check_state("R3 zero word", 2'b11);
    do_write(32'hBEEF_0000, 4'hF); check_state("R3 wrong key", 2'b11);
    do_write(32'hDEAC_0000, 4'hF); check_state("R4 one bit off", 2'b11);
    do_write(32'hADDE_0000, 4'hF); check_state("R4 byte swapped", 2'b11);
    do_write(32'h0000_DEAD, 4'hF); check_state("R4 key in low half", 2'b11);
  endtask

  task automatic t_mid_bits;
    do_write(32'hDEAD_FFFD, 4'hF); check_state("R7 junk middle bits", 2'b01);
    check("R5 upper bits zero", rd_data & 32'hFFFF_FFFC, 32'h0);
  endtask

  task automatic t_strobes;
    do_write(32'hDEAD_0002, 4'h0); check_state("R6 zero strobes", 2'b10);
    do_write(32'hDEAD_0001, 4'h8); check_state("R6 partial strobes", 2'b01);
  endtask

  task automatic t_hold;
    repeat (10) @(negedge clk);
    check_state("R8 idle hold", 2'b01);
  endtask

  task automatic t_single_word;
    do_write(32'hDEAD_0000, 4'hF); check_state("R9 keyed write", 2'b00);
    do_write(32'h0000_0003, 4'hF); check_state("R9 next unkeyed", 2'b00);
  endtask

  task automatic t_reset_again;
    rst_n = 1'b0;
    @(negedge clk);
    check_state("R1 mid-run reset", 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 mid-run release", 2'b11);
  endtask

  initial begin
    t_reset();
    t_keyed();
    t_no_key();
    t_mid_bits();
    t_strobes();
    t_hold();
    t_single_word();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule